// File: doc/BRIEF.md
# Serial Transfer Buffer Address Sequencer

This block holds the 128-byte data memory of one serial channel and steps through it for a byte-wide serial shift engine. Software sets up a transfer with three configuration inputs and a one-cycle start pulse. The inputs are a layout select, an offset and a byte count. The engine then works byte by byte. It raises `req` to fetch the next byte to send, and it raises `rx_valid` to hand back the byte it received. Once the last received byte has been stored, the block raises a one-cycle `done`.

There are two memory layouts. In shared layout, each byte is sent from one location and the received byte replaces it in that same location. In split layout, the send area and the receive area are half the memory apart, and each area holds at most 64 bytes. In both layouts the offset is added to every address, and all address arithmetic wraps inside the 128-byte window. Locations outside the active transfer stay free for software data.

A processor port can read and write any byte of the memory at any time. The memory has a single port, so the sequencer wins when both want it in the same cycle. The processor is then held off for that cycle through a ready signal. The engine is expected never to raise `req` and `rx_valid` together. If it does, the receive write is served and the fetch is dropped.

Top module: `sio_buf_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `done`, `tx_valid` and `cpu_rvalid` are 0 and `cpu_ready` is 1.
- R2: A processor access is taken at a clock edge where `cpu_en` and `cpu_ready` are both high. A write (`cpu_we`=1) stores `cpu_wdata` at `cpu_addr`, where address 0 is the first byte of the window. A read raises `cpu_rvalid` for one cycle in the next cycle, with the byte on `cpu_rdata`.
- R3: In shared layout (`cfg_split`=0), transfer byte n (counting from 0) is sent from address (offset+n) mod 128, and its received byte is written to that same address.
- R4: In split layout (`cfg_split`=1), byte n is sent from (offset+n) mod 128 and received into (offset+n+64) mod 128.
- R5: Only the low 7 bits of `cfg_offset` take part, and any address past 127 wraps back to 0.
- R6: The number of bytes per transfer is `cfg_count`. A count of 0 means 128 in shared layout and 64 in split layout. Counts above 64 in split layout are limited to 64, and counts above 128 in shared layout are limited to 128.
- R7: Addresses that the current transfer does not write keep their contents.
- R8: While a transfer is active, a `req` cycle leads to `tx_valid`=1 and the send byte on `tx_data` in the following cycle. When no transfer is active, `req` gives no `tx_valid` and `rx_valid` writes nothing.
- R9: `done` is high for exactly one cycle, the cycle after the `rx_valid` of the last byte. After that the transfer is inactive until the next `start`, which restarts at byte 0.
- R10: `cpu_ready` is 0 exactly in the cycles where an active transfer sees `req` or `rx_valid`. A processor access held off this way is not performed and is taken later, once ready returns.
- R11: Layout, offset and count are captured at `start`. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 1 | Layout select: 0 shared, 1 split |
| cfg_offset | input | 8 | Address offset added to every transfer address |
| cfg_count | input | 8 | Transfer byte count |
| start | input | 1 | Begins a transfer and captures the configuration |
| req | input | 1 | Engine asks for the next send byte |
| tx_valid | output | 1 | Send byte valid on `tx_data` |
| tx_data | output | 8 | Send byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cpu_en | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write select |
| cpu_addr | input | 7 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_ready | output | 1 | Processor access can be taken this cycle |
| cpu_rdata | output | 8 | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |

## Verification
The collision to provoke is a processor access that lands in the same cycle as a sequencer memory access. The bench first raises `cpu_en` with a write in the same cycle as `req`, and then raises `cpu_en` with a read in the same cycle as `rx_valid`. In each case it expects `cpu_ready` low in the shared cycle and high in the next one. It also expects the send byte to be unaffected, the read data to arrive one cycle later than it would without the clash, and a final read-back to show the written byte and the received byte each at their own address.

// File: rtl/sio_buf_pkg.sv
package sio_buf_pkg;

  parameter int unsigned SB_DATA_W = 8;
  parameter int unsigned SB_DEPTH  = 128;
  parameter int unsigned SB_OFFS_W = 8;
  parameter int unsigned SB_CNT_W  = 8;

  // who drives the single memory port in a given cycle
  typedef enum logic [1:0] {
    OWN_NONE   = 2'd0,
    OWN_SEQ_RD = 2'd1,
    OWN_SEQ_WR = 2'd2,
    OWN_CPU    = 2'd3
  } ram_owner_e;

endpackage

// File: rtl/sio_buf_ram.sv
module sio_buf_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end

endmodule

// File: rtl/sio_addr_gen.sv
module sio_addr_gen #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          split,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] tx_addr,
  output logic [AW-1:0] rx_addr
);

  localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);

  // AW-bit sums wrap inside the window by construction
  always_comb begin
    tx_addr = offset + idx;
    rx_addr = split ? (tx_addr + HALF) : tx_addr;
  end

endmodule

// File: rtl/sio_xfer_ctrl.sv
module sio_xfer_ctrl #(
  parameter int DEPTH  = 128,
  parameter int OFFS_W = 8,
  parameter int CNT_W  = 8,
  parameter int AW     = $clog2(DEPTH),
  parameter int LEN_W  = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_split,
  input  logic [OFFS_W-1:0] cfg_offset,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              req,
  input  logic              rx_valid,
  output logic              busy,
  output logic [AW-1:0]     idx,
  output logic [LEN_W-1:0]  len_q,
  output logic              split_q,
  output logic [AW-1:0]     offset_q,
  output logic              seq_rd,
  output logic              seq_wr,
  output logic              tx_valid,
  output logic              done
);

  localparam int CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [CMP_W-1:0] cnt_x, full_x, len_x;
  logic [LEN_W-1:0] idx_next;
  logic             last;

  generate
    if (OFFS_W > AW) begin : g_offs_hi
      logic unused_offs_hi;
      assign unused_offs_hi = ^cfg_offset[OFFS_W-1:AW];
    end
  endgenerate

  // byte count resolution: zero means full area, larger values saturate
  always_comb begin
    cnt_x  = CMP_W'(cfg_count);
    full_x = cfg_split ? CMP_W'(DEPTH / 2) : CMP_W'(DEPTH);
    len_x  = ((cnt_x == '0) || (cnt_x > full_x)) ? full_x : cnt_x;
  end

  assign seq_wr   = busy & rx_valid;
  assign seq_rd   = busy & req & ~rx_valid;
  assign idx_next = {1'b0, idx} + LEN_W'(1);
  assign last     = (idx_next == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      len_q    <= '0;
      split_q  <= 1'b0;
      offset_q <= '0;
      tx_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      tx_valid <= seq_rd;
      if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        split_q  <= cfg_split;
        offset_q <= cfg_offset[AW-1:0];
        len_q    <= LEN_W'(len_x);
      end else if (seq_wr) begin
        if (last) begin
          busy <= 1'b0;
          idx  <= '0;
          done <= 1'b1;
        end else begin
          idx <= idx + AW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sio_ram_arb.sv
module sio_ram_arb
  import sio_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_rd,
  input  logic              seq_wr,
  input  logic [AW-1:0]     tx_addr,
  input  logic [AW-1:0]     rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);

  ram_owner_e owner;

  always_comb begin
    if (seq_wr)      owner = OWN_SEQ_WR;
    else if (seq_rd) owner = OWN_SEQ_RD;
    else if (cpu_en) owner = OWN_CPU;
    else             owner = OWN_NONE;
  end

  assign cpu_ready = ~(seq_rd | seq_wr);

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cpu_addr;
    ram_wdata = cpu_wdata;
    unique case (owner)
      OWN_SEQ_WR: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_addr  = rx_addr;
        ram_wdata = rx_data;
      end
      OWN_SEQ_RD: begin
        ram_en   = 1'b1;
        ram_addr = tx_addr;
      end
      OWN_CPU: begin
        ram_en = 1'b1;
        ram_we = cpu_we;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rvalid <= 1'b0;
    else     cpu_rvalid <= (owner == OWN_CPU) & ~cpu_we;
  end

endmodule

// File: rtl/sio_buf_seq.sv
module sio_buf_seq #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int OFFS_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_split,
  input  logic [OFFS_W-1:0]        cfg_offset,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic                     start,
  input  logic                     req,
  output logic                     tx_valid,
  output logic [DATA_W-1:0]        tx_data,
  input  logic                     rx_valid,
  input  logic [DATA_W-1:0]        rx_data,
  output logic                     done,
  input  logic                     cpu_en,
  input  logic                     cpu_we,
  input  logic [$clog2(DEPTH)-1:0] cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ready,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_rvalid
);

  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = AW + 1;

  logic              busy_w, split_w, seq_rd_w, seq_wr_w;
  logic [AW-1:0]     idx_w, offset_w, tx_addr_w, rx_addr_w;
  logic [LEN_W-1:0]  len_w;
  logic              ram_en_w, ram_we_w;
  logic [AW-1:0]     ram_addr_w;
  logic [DATA_W-1:0] ram_wdata_w, ram_q_w;

  sio_xfer_ctrl #(
    .DEPTH(DEPTH), .OFFS_W(OFFS_W), .CNT_W(CNT_W), .AW(AW), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .cfg_split(cfg_split), .cfg_offset(cfg_offset), .cfg_count(cfg_count),
    .req(req), .rx_valid(rx_valid),
    .busy(busy_w), .idx(idx_w), .len_q(len_w),
    .split_q(split_w), .offset_q(offset_w),
    .seq_rd(seq_rd_w), .seq_wr(seq_wr_w),
    .tx_valid(tx_valid), .done(done)
  );

  sio_addr_gen #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .split(split_w), .offset(offset_w), .idx(idx_w),
    .tx_addr(tx_addr_w), .rx_addr(rx_addr_w)
  );

  sio_ram_arb #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_arb (
    .clk(clk), .rst(rst),
    .seq_rd(seq_rd_w), .seq_wr(seq_wr_w),
    .tx_addr(tx_addr_w), .rx_addr(rx_addr_w), .rx_data(rx_data),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .ram_en(ram_en_w), .ram_we(ram_we_w), .ram_addr(ram_addr_w), .ram_wdata(ram_wdata_w)
  );

  sio_buf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .en(ram_en_w), .we(ram_we_w), .addr(ram_addr_w),
    .wdata(ram_wdata_w), .q(ram_q_w)
  );

  assign tx_data   = ram_q_w;
  assign cpu_rdata = ram_q_w;

endmodule

// File: rtl/sio_buf_seq_chk.sv
module sio_buf_seq_chk #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int LEN_W = AW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             rx_valid,
  input logic             tx_valid,
  input logic             done,
  input logic             cpu_en,
  input logic             cpu_we,
  input logic             cpu_ready,
  input logic             cpu_rvalid,
  input logic             busy,
  input logic [AW-1:0]    idx,
  input logic [LEN_W-1:0] len_q,
  input logic             split_q
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rx_valid));

  // R8
  tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(req));

  // R8
  idle_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> !tx_valid);

  // R10
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_ready |-> (req || rx_valid));

  // R10
  seq_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (req || rx_valid)) |-> !cpu_ready);

  // R2
  read_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && cpu_ready && !cpu_we) |=> cpu_rvalid);

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, idx} < len_q));

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len_q != '0 && len_q <= (split_q ? LEN_W'(DEPTH / 2) : LEN_W'(DEPTH))));

endmodule

bind sio_buf_seq sio_buf_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req(req), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .done(done), .cpu_en(cpu_en), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .busy(busy_w), .idx(idx_w), .len_q(len_w), .split_q(split_w)
);

// File: tb/sio_buf_seq_bench.sv
module sio_buf_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_split = 1'b0;
  logic [7:0] cfg_offset = '0, cfg_count = '0;
  logic       start = 1'b0, req = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       cpu_en = 1'b0, cpu_we = 1'b0;
  logic [6:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       tx_valid, done, cpu_ready, cpu_rvalid;
  logic [7:0] tx_data, cpu_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  sio_buf_seq u_sio_buf_seq (
    .clk(clk), .rst(rst), .cfg_split(cfg_split), .cfg_offset(cfg_offset),
    .cfg_count(cfg_count), .start(start), .req(req), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  // {split, offset, count, expected byte count}
  localparam logic [24:0] VEC [0:6] = '{
    {1'b0, 8'h00, 8'd5,   8'd5},    // R3 plain shared
    {1'b0, 8'h7E, 8'd4,   8'd4},    // R5 wrap past the top
    {1'b1, 8'h10, 8'd8,   8'd8},    // R4 split
    {1'b1, 8'h3E, 8'd70,  8'd64},   // R6 split clamp, R5 receive wrap
    {1'b0, 8'h85, 8'd0,   8'd128},  // R6 zero in shared, R5 bit 7 ignored
    {1'b1, 8'h00, 8'd0,   8'd64},   // R6 zero in split
    {1'b0, 8'h03, 8'd200, 8'd128}   // R6 shared clamp
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = 7'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input int a, output logic [7:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = 7'(a);
    @(negedge clk);
    cpu_en = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic pulse_start(input logic s, input logic [7:0] o, input logic [7:0] c);
    @(negedge clk);
    cfg_split = s; cfg_offset = o; cfg_count = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one byte: fetch, check send data, deliver receive data, check done
  task automatic xfer_byte(input int ta, input int ra, input logic [7:0] rd,
                           input bit last, input string tag);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(tx_valid === 1'b1, {tag, " R8 tx_valid"}, int'(tx_valid), 1);
    check(tx_data === model[ta], {tag, " tx_data"}, int'(tx_data), int'(model[ta]));
    rx_valid = 1'b1; rx_data = rd;
    @(negedge clk);
    rx_valid = 1'b0;
    model[ra] = rd;
    check(done === last, {tag, " R6/R9 done"}, int'(done), int'(last));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    check(done === 1'b0 && tx_valid === 1'b0 && cpu_rvalid === 1'b0,
          "R1 outputs low", int'({done, tx_valid, cpu_rvalid}), 0);
    check(cpu_ready === 1'b1, "R1 ready", int'(cpu_ready), 1);

    // R2 write then read, with rvalid timing
    cpu_write(9, 8'h96);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = 7'd9;
    @(negedge clk);
    cpu_en = 1'b0;
    check(cpu_rvalid === 1'b1, "R2 rvalid", int'(cpu_rvalid), 1);
    check(cpu_rdata === 8'h96, "R2 rdata", int'(cpu_rdata), 8'h96);
    @(negedge clk);
    check(cpu_rvalid === 1'b0, "R2 rvalid one cycle", int'(cpu_rvalid), 0);

    // R8 idle traffic is ignored
    cpu_write(0, 8'h11);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(tx_valid === 1'b0, "R8 idle req", int'(tx_valid), 0);
    rx_valid = 1'b1; rx_data = 8'hEE;
    @(negedge clk); rx_valid = 1'b0;
    cpu_read(0, rv);
    check(rv === 8'h11, "R8 idle rx write", int'(rv), 8'h11);

    // table of transfers
    for (int v = 0; v < 7; v++) begin
      logic       sp;
      logic [7:0] of, ct;
      int         n_exp;
      sp = VEC[v][24]; of = VEC[v][23:16]; ct = VEC[v][15:8]; n_exp = int'(VEC[v][7:0]);
      for (int i = 0; i < 128; i++) begin
        model[i] = 8'(i * 7 + v * 13) ^ 8'h5A;
        cpu_write(i, model[i]);
      end
      pulse_start(sp, of, ct);
      for (int n = 0; n < n_exp; n++) begin
        int ta, ra;
        ta = (int'(of) + n) % 128;         // R5
        ra = sp ? (ta + 64) % 128 : ta;    // R3 R4
        xfer_byte(ta, ra, 8'(n * 3) ^ 8'(v << 5) ^ 8'hC1, n == n_exp - 1,
                  sp ? "R4 vec" : "R3 vec");
      end
      @(negedge clk);
      check(done === 1'b0, "R9 done width", int'(done), 0);
      for (int i = 0; i < 128; i++) begin
        cpu_read(i, rv);
        check(rv === model[i], "R7 readback", int'(rv), int'(model[i]));
      end
    end

    // R11 configuration captured at start
    pulse_start(1'b0, 8'h10, 8'd2);
    cfg_split = 1'b1; cfg_offset = 8'h50; cfg_count = 8'd1;
    xfer_byte(16'h10, 16'h10, 8'h71, 1'b0, "R11 byte0");
    xfer_byte(16'h11, 16'h11, 8'h72, 1'b1, "R11 byte1");
    cpu_read(16'h10, rv);
    check(rv === 8'h71, "R11 rx addr", int'(rv), 8'h71);
    cpu_read(16'h50, rv);
    check(rv === model[16'h50], "R11 untouched", int'(rv), int'(model[16'h50]));

    // R10 collisions with the processor port
    pulse_start(1'b0, 8'h20, 8'd1);
    @(negedge clk);
    req = 1'b1; cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = 7'd5; cpu_wdata = 8'hC3;
    #1 check(cpu_ready === 1'b0, "R10 stall on req", int'(cpu_ready), 0);
    @(negedge clk);
    req = 1'b0;
    #1 check(cpu_ready === 1'b1, "R10 ready back", int'(cpu_ready), 1);
    check(tx_valid === 1'b1 && tx_data === model[16'h20], "R10 send byte intact",
          int'(tx_data), int'(model[16'h20]));
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
    model[5] = 8'hC3;
    rx_valid = 1'b1; rx_data = 8'h3C; cpu_en = 1'b1; cpu_addr = 7'd5;
    #1 check(cpu_ready === 1'b0, "R10 stall on rx", int'(cpu_ready), 0);
    @(negedge clk);
    rx_valid = 1'b0;
    model[16'h20] = 8'h3C;
    check(done === 1'b1, "R9 done after collision", int'(done), 1);
    check(cpu_rvalid === 1'b0, "R10 stalled read", int'(cpu_rvalid), 0);
    @(negedge clk);
    cpu_en = 1'b0;
    check(cpu_rvalid === 1'b1 && cpu_rdata === 8'hC3, "R10 late read",
          int'(cpu_rdata), 8'hC3);
    cpu_read(16'h20, rv);
    check(rv === 8'h3C, "R10 rx write", int'(rv), 8'h3C);

    // R9 traffic after done is ignored and ready stays high
    @(negedge clk);
    req = 1'b1;
    #1 check(cpu_ready === 1'b1, "R10 idle ready", int'(cpu_ready), 1);
    @(negedge clk);
    req = 1'b0;
    check(tx_valid === 1'b0, "R9 req after done", int'(tx_valid), 0);

    // R9 restart begins at byte 0
    pulse_start(1'b0, 8'h20, 8'd1);
    xfer_byte(16'h20, 16'h20, 8'h44, 1'b1, "R9 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule